// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations for a 32-bit address space with 4 KiB pages. A lookup presents a virtual address and an access kind. In the same cycle, every stored tag is compared against the virtual page number. The block returns a hit flag, the physical address and a protection-fault flag. The low 12 bits of the address pass straight through as the page offset.

Each slot holds a virtual-page tag, a physical frame number, two permission bits, a valid bit, a use bit and a dirty bit. The dirty bit describes the page itself, not the slot. Miss-handling logic outside the block walks the page table and writes a translation through the refill port. The refill copies the status bits exactly as they appear in the page table.

Software that changes a page-table entry's frame or permissions first removes the stale copy through the maintenance port. It can remove one translation by virtual page number, or flush every slot at once. A later refill then brings in the updated bits. A write to a clean page is reported as a miss, so the miss handler can mark the page dirty in the table and refill the slot.

Top module: `xlate_buffer`

## Requirements
- R1: After a synchronous active-low reset, no slot is valid. Every lookup then returns hit=0, fault=0, used=0, and a physical address whose upper 20 bits are zero and whose low 12 bits equal the virtual offset.
- R2: A lookup whose virtual page number equals the tag of any valid slot, in any of the 16 positions, matches that slot in the same cycle. On a hit the physical address is {frame number, vaddr[11:0]}. On no hit, the upper 20 bits of the physical address are zero.
- R3: Permission bit 0 allows reads and bit 1 allows writes (lk_is_write=0 means read, 1 means write). A matching access that is not allowed gives fault=1 and hit=0. A hit and a fault are never reported together.
- R4: A permitted write that matches a slot whose dirty bit is 0 gives hit=0 and fault=0. After a refill with dirty=1, the same write hits.
- R5: lk_used shows the use bit of the matching slot and is 0 when nothing matches. A refill sets the use bit, and lookups never clear it. Any hit therefore reports used=1.
- R6: A refill takes effect at the next clock edge. When any slot is invalid, the refill goes into the lowest-numbered invalid slot.
- R7: When all slots are valid, the refill goes into the slot named by a round-robin pointer. The pointer is 0 after reset. It advances by one, wrapping from 15 to 0, only on a refill that uses it.
- R8: A refill whose virtual page number already matches a valid slot overwrites that slot. It leaves every other slot and the round-robin pointer unchanged.
- R9: A single invalidate clears only the valid slot whose tag equals the given page number. If no slot matches, it changes nothing.
- R10: Flush-all clears every valid bit at one clock edge. A refill in the same cycle is still installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_is_write | input | 1 | Lookup access kind: 0 read, 1 write |
| lk_hit | output | 1 | Translation usable for this access |
| lk_fault | output | 1 | Matching slot forbids this access |
| lk_used | output | 1 | Use bit of the matching slot |
| lk_paddr | output | 32 | Physical address |
| rf_valid | input | 1 | Install a translation at the next edge |
| rf_vpn | input | 20 | Virtual page number to install |
| rf_pfn | input | 20 | Physical frame number to install |
| rf_perm | input | 2 | Permission bits to install (bit 0 read, bit 1 write) |
| rf_dirty | input | 1 | Page dirty bit copied from the page table |
| inv_one | input | 1 | Remove the translation for inv_vpn |
| inv_vpn | input | 20 | Page number to remove |
| inv_all | input | 1 | Remove every translation |

## Verification
The assertions rely on two things about the inputs. Refill and lookup inputs are driven to known values from reset onward. No refill places a page number that duplicates a different slot, and the slot-reuse rule guarantees this on its own. The one-hot match check, and the checks that slot contents follow refills and invalidates, also need clean control strobes on every sampled edge. The bench changes each input only on the falling clock edge and releases every strobe before the next one. It never raises flush-all and single invalidate in the same cycle, apart from the one directed case that combines flush-all with a refill.

// File: rtl/xb_pkg.sv
// Package: shared encodings for the translation buffer.
// Assumes: permission field is two bits wide, read right in bit 0.
package xb_pkg;
    typedef enum logic {
        XB_READ  = 1'b0,
        XB_WRITE = 1'b1
    } xb_access_e;

    localparam int XB_PERM_W  = 2;
    localparam int XB_PERM_RD = 0;
    localparam int XB_PERM_WR = 1;
endpackage

// File: rtl/xb_tag_match.sv
// Module: xb_tag_match
// Compares one page number against every slot tag in parallel and
// produces a match vector, an any-match flag and the encoded index.
// Assumes: at most one valid slot holds a given tag, so OR-encoding
// the matching indices yields the single matching index.
module xb_tag_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]              vpn,
    output logic [ENTRIES-1:0]            match,
    output logic                          any,
    output logic [IDX_W-1:0]              idx
);
    // One comparator per slot, gated by the slot's valid bit.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == vpn);
    end

    assign any = |match;

    // Encode the matching slot number.
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/xb_victim.sv
// Module: xb_victim
// Chooses the slot a refill writes. It reuses a slot already holding
// the page, else takes the lowest invalid slot, else the round-robin
// pointer. The pointer moves only when it is the one that was used.
// Assumes: reuse_idx is meaningful whenever reuse is high.
module xb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic               refill,
    input  logic               reuse,
    input  logic [IDX_W-1:0]   reuse_idx,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_ptr;
    logic             all_valid;
    logic             use_ptr;

    assign all_valid = &valid;
    assign use_ptr   = refill && !reuse && all_valid;

    // Priority encoder: lowest-numbered invalid slot.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    // Victim selection in priority order.
    always_comb begin
        if (reuse)           victim = reuse_idx;
        else if (!all_valid) victim = free_idx;
        else                 victim = rr_ptr;
    end

    // Round-robin pointer, advanced only when it picked the victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (use_ptr) begin
            if (rr_ptr == IDX_W'(ENTRIES - 1)) rr_ptr <= '0;
            else                              rr_ptr <= rr_ptr + 1'b1;
        end
    end

    // A new page never overwrites a live slot while a free one exists.
    assert_victim_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (refill && !reuse && !all_valid) |-> !valid[victim]);

    // The pointer stays put unless a full-buffer refill consumed it.
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(refill && !reuse && all_valid) |=> $stable(rr_ptr));
endmodule

// File: rtl/xb_entry_array.sv
// Module: xb_entry_array
// Slot storage: tag, frame, permissions, dirty and use bits, plus the
// valid vector with its invalidate and refill update rules.
// Assumes: victim and inv_hit are computed from the current contents.
module xb_entry_array #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    rf_valid,
    input  logic [IDX_W-1:0]                        victim,
    input  logic [VPN_W-1:0]                        rf_vpn,
    input  logic [PFN_W-1:0]                        rf_pfn,
    input  logic [xb_pkg::XB_PERM_W-1:0]            rf_perm,
    input  logic                                    rf_dirty,
    input  logic                                    inv_one,
    input  logic [ENTRIES-1:0]                      inv_hit,
    input  logic                                    inv_all,
    output logic [ENTRIES-1:0]                      valid_q,
    output logic [ENTRIES-1:0]                      use_q,
    output logic [ENTRIES-1:0]                      dirty_q,
    output logic [ENTRIES-1:0][VPN_W-1:0]           tag_q,
    output logic [ENTRIES-1:0][PFN_W-1:0]           pfn_q,
    output logic [ENTRIES-1:0][xb_pkg::XB_PERM_W-1:0] perm_q
);
    logic [ENTRIES-1:0] valid_d;
    logic [ENTRIES-1:0] use_d;

    // Next valid vector: invalidations first, then the refill wins.
    always_comb begin
        valid_d = valid_q;
        if (inv_all)      valid_d = '0;
        else if (inv_one) valid_d = valid_q & ~inv_hit;
        if (rf_valid)     valid_d[victim] = 1'b1;
    end

    // Next use vector: a refill loads the use bit as set.
    always_comb begin
        use_d = use_q;
        if (rf_valid) use_d[victim] = 1'b1;
    end

    // Status registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            use_q   <= '0;
        end else begin
            valid_q <= valid_d;
            use_q   <= use_d;
        end
    end

    // Payload registers, written only by a refill.
    always_ff @(posedge clk) begin
        if (rf_valid) begin
            tag_q[victim]   <= rf_vpn;
            pfn_q[victim]   <= rf_pfn;
            perm_q[victim]  <= rf_perm;
            dirty_q[victim] <= rf_dirty;
        end
    end

    // The refilled slot is live at the next edge, even during a flush.
    assert_refill_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid |=> valid_q[$past(victim)]);

    // A refill leaves the use bit of its slot set.
    assert_refill_use_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid |=> use_q[$past(victim)]);

    // A flush without refill empties the buffer in one edge.
    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !rf_valid) |=> (valid_q == '0));

    // A single invalidate removes exactly the matching slot.
    assert_inv_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_one && !inv_all && !rf_valid) |=>
            (valid_q == ($past(valid_q) & ~$past(inv_hit))));
endmodule

// File: rtl/xlate_buffer.sv
// Module: xlate_buffer (top)
// Fully associative translation buffer with same-cycle lookup, refill
// from external miss handling, and single/all invalidation. It checks
// permissions and the page dirty bit on every lookup.
// Assumes: addresses split as {page number, PAGE_BITS offset}.
module xlate_buffer #(
    parameter int ENTRIES   = 16,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PFN_W    = PA_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [VA_W-1:0]              lk_vaddr,
    input  logic                         lk_is_write,
    output logic                         lk_hit,
    output logic                         lk_fault,
    output logic                         lk_used,
    output logic [PA_W-1:0]              lk_paddr,
    input  logic                         rf_valid,
    input  logic [VPN_W-1:0]             rf_vpn,
    input  logic [PFN_W-1:0]             rf_pfn,
    input  logic [xb_pkg::XB_PERM_W-1:0] rf_perm,
    input  logic                         rf_dirty,
    input  logic                         inv_one,
    input  logic [VPN_W-1:0]             inv_vpn,
    input  logic                         inv_all
);
    import xb_pkg::*;

    logic [ENTRIES-1:0]                  valid_q, use_q, dirty_q;
    logic [ENTRIES-1:0][VPN_W-1:0]       tag_q;
    logic [ENTRIES-1:0][PFN_W-1:0]       pfn_q;
    logic [ENTRIES-1:0][XB_PERM_W-1:0]   perm_q;

    logic [ENTRIES-1:0] lk_match, rf_match, inv_match;
    logic               lk_any, rf_any, inv_any;
    logic [IDX_W-1:0]   lk_idx, rf_idx, inv_idx;
    logic [IDX_W-1:0]   victim;

    xb_access_e          access;
    logic [XB_PERM_W-1:0] sel_perm;
    logic                 sel_dirty;
    logic                 perm_ok;

    // Three parallel comparator banks: lookup, refill reuse, invalidate.
    xb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
        .valid(valid_q), .tags(tag_q), .vpn(lk_vaddr[VA_W-1:PAGE_BITS]),
        .match(lk_match), .any(lk_any), .idx(lk_idx));

    xb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_rf_match (
        .valid(valid_q), .tags(tag_q), .vpn(rf_vpn),
        .match(rf_match), .any(rf_any), .idx(rf_idx));

    xb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_inv_match (
        .valid(valid_q), .tags(tag_q), .vpn(inv_vpn),
        .match(inv_match), .any(inv_any), .idx(inv_idx));

    xb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(valid_q), .refill(rf_valid),
        .reuse(rf_any), .reuse_idx(rf_idx), .victim(victim));

    xb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rf_valid(rf_valid), .victim(victim),
        .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_perm(rf_perm),
        .rf_dirty(rf_dirty), .inv_one(inv_one), .inv_hit(inv_match),
        .inv_all(inv_all), .valid_q(valid_q), .use_q(use_q),
        .dirty_q(dirty_q), .tag_q(tag_q), .pfn_q(pfn_q), .perm_q(perm_q));

    // Select the matching slot's status and judge the access.
    always_comb begin
        access    = xb_access_e'(lk_is_write);
        sel_perm  = perm_q[lk_idx];
        sel_dirty = dirty_q[lk_idx];
        perm_ok   = (access == XB_WRITE) ? sel_perm[XB_PERM_WR]
                                         : sel_perm[XB_PERM_RD];
        lk_fault  = lk_any && !perm_ok;
        lk_hit    = lk_any && perm_ok && ((access == XB_READ) || sel_dirty);
        lk_used   = lk_any && use_q[lk_idx];
    end

    // Physical address: frame on a hit, offset always passed through.
    always_comb begin
        lk_paddr = {{PFN_W{1'b0}}, lk_vaddr[PAGE_BITS-1:0]};
        if (lk_hit) lk_paddr[PA_W-1:PAGE_BITS] = pfn_q[lk_idx];
    end

    // At most one slot ever matches a page number.
    assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // Hit and fault are mutually exclusive.
    assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_fault));

    // Every hit comes from a slot that a refill loaded.
    assert_hit_used_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_used);

    // A write hit is only possible on a dirty page.
    assert_write_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_is_write) |-> |(lk_match & dirty_q));

    // Invalidate lookups do not disturb the lookup result path.
    assert_inv_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_one && !inv_any && !inv_all && !rf_valid) |=> $stable(valid_q));
endmodule

// File: tb/xlate_buffer_bench.sv
module xlate_buffer_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_LOOK = 2'd0, OP_FILL = 2'd1,
                           OP_INV1 = 2'd2, OP_FLSH = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] vpn;
        logic [11:0] off;
        logic [19:0] pfn;
        logic [1:0]  perm;
        logic        dirty;
        logic        wr;
        logic        e_hit;
        logic        e_fault;
        logic        e_used;
        logic [31:0] e_pa;
    } vec_t;

    // op, vpn, off, pfn, perm, dirty, wr, hit, fault, used, paddr
    localparam vec_t VEC [22] = '{
        '{OP_LOOK, 20'h12345, 12'habc, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000abc}, // R1
        '{OP_FILL, 20'h12345, 12'h000, 20'h0beef, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{OP_LOOK, 20'h12345, 12'h123, 20'h0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0beef123}, // R2
        '{OP_LOOK, 20'h12345, 12'h123, 20'h0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00000123}, // R4
        '{OP_FILL, 20'h12345, 12'h000, 20'h0beef, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{OP_LOOK, 20'h12345, 12'h456, 20'h0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0beef456}, // R4
        '{OP_FILL, 20'h00777, 12'h000, 20'h11111, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{OP_LOOK, 20'h00777, 12'h0ff, 20'h0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h000000ff}, // R3
        '{OP_LOOK, 20'h00777, 12'hfff, 20'h0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h11111fff}, // R3
        '{OP_FILL, 20'hfffff, 12'h000, 20'h22222, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{OP_LOOK, 20'hfffff, 12'h001, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00000001}, // R3
        '{OP_LOOK, 20'hfffff, 12'h000, 20'h0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h22222000}, // R2
        '{OP_INV1, 20'h00aaa, 12'h000, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{OP_LOOK, 20'h12345, 12'h010, 20'h0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0beef010}, // R9
        '{OP_INV1, 20'h00777, 12'h000, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{OP_LOOK, 20'h00777, 12'h020, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000020}, // R9
        '{OP_LOOK, 20'hfffff, 12'h030, 20'h0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h22222030}, // R9
        '{OP_FILL, 20'h12345, 12'h000, 20'h33333, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{OP_LOOK, 20'h12345, 12'h010, 20'h0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h33333010}, // R8
        '{OP_FLSH, 20'h00000, 12'h000, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},
        '{OP_LOOK, 20'hfffff, 12'h040, 20'h0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000040}, // R10
        '{OP_LOOK, 20'h12345, 12'h050, 20'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000050}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_is_write = 1'b0;
    logic        lk_hit, lk_fault, lk_used;
    logic [31:0] lk_paddr;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [19:0] rf_pfn = '0;
    logic [1:0]  rf_perm = '0;
    logic        rf_dirty = 1'b0;
    logic        inv_one = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        inv_all = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlate_buffer u_xlate_buffer (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_is_write(lk_is_write),
        .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_used(lk_used), .lk_paddr(lk_paddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_perm(rf_perm),
        .rf_dirty(rf_dirty), .inv_one(inv_one), .inv_vpn(inv_vpn), .inv_all(inv_all));

    task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic wr,
                        input logic e_hit, input logic e_fault, input logic e_used,
                        input logic [31:0] e_pa, input string req);
        @(negedge clk);
        lk_vaddr    = {vpn, off};
        lk_is_write = wr;
        #1;
        checks++;
        if (lk_hit !== e_hit || lk_fault !== e_fault || lk_used !== e_used ||
            lk_paddr !== e_pa) begin
            fails++;
            $display("FAIL %s vpn=%h wr=%0b actual hit=%0b fault=%0b used=%0b pa=%h expected hit=%0b fault=%0b used=%0b pa=%h",
                     req, vpn, wr, lk_hit, lk_fault, lk_used, lk_paddr,
                     e_hit, e_fault, e_used, e_pa);
        end
    endtask

    task automatic hit_rd(input logic [19:0] vpn, input logic [19:0] pfn, input string req);
        look(vpn, 12'h5a5, 1'b0, 1'b1, 1'b0, 1'b1, {pfn, 12'h5a5}, req);
    endtask

    task automatic miss_rd(input logic [19:0] vpn, input string req);
        look(vpn, 12'h5a5, 1'b0, 1'b0, 1'b0, 1'b0, {20'h0, 12'h5a5}, req);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [1:0] perm, input logic dirty);
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = vpn; rf_pfn = pfn; rf_perm = perm; rf_dirty = dirty;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic kill_one(input logic [19:0] vpn);
        @(negedge clk);
        inv_one = 1'b1; inv_vpn = vpn;
        @(negedge clk);
        inv_one = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        miss_rd(20'h00000, "R1");
        look(20'habcde, 12'h7ff, 1'b1, 1'b0, 1'b0, 1'b0, 32'h000007ff, "R1");

        // Vector walk: R2 R3 R4 R8 R9 R10
        for (int i = 0; i < 22; i++) begin
            case (VEC[i].op)
                OP_LOOK: look(VEC[i].vpn, VEC[i].off, VEC[i].wr, VEC[i].e_hit,
                              VEC[i].e_fault, VEC[i].e_used, VEC[i].e_pa, "vector");
                OP_FILL: fill(VEC[i].vpn, VEC[i].pfn, VEC[i].perm, VEC[i].dirty);
                OP_INV1: kill_one(VEC[i].vpn);
                default: flush();
            endcase
        end

        // R6: fill all 16 slots in order, every one present
        for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 2'd3, 1'b1);
        for (int i = 0; i < 16; i++) hit_rd(20'h00100 + 20'(i), 20'h00200 + 20'(i), "R6");

        // R6: reuse of lowest free slots 3 then 9, pointer untouched
        kill_one(20'h00103);
        kill_one(20'h00109);
        fill(20'h00300, 20'h00400, 2'd3, 1'b1);
        fill(20'h00301, 20'h00401, 2'd3, 1'b1);
        hit_rd(20'h00300, 20'h00400, "R6");
        hit_rd(20'h00301, 20'h00401, "R6");
        hit_rd(20'h00100, 20'h00200, "R6");

        // R7: full buffer evicts slots 0,1,2,3 in turn
        for (int i = 2; i < 6; i++) fill(20'h00300 + 20'(i), 20'h00400 + 20'(i), 2'd3, 1'b1);
        miss_rd(20'h00100, "R7");
        miss_rd(20'h00101, "R7");
        miss_rd(20'h00102, "R7");
        miss_rd(20'h00300, "R7");
        hit_rd(20'h00301, 20'h00401, "R7");
        hit_rd(20'h00104, 20'h00204, "R7");

        // R7: twelve more refills take slots 4..15, then the pointer wraps to 0
        for (int i = 6; i < 18; i++) fill(20'h00300 + 20'(i), 20'h00400 + 20'(i), 2'd3, 1'b1);
        miss_rd(20'h00104, "R7");
        hit_rd(20'h00302, 20'h00402, "R7");
        fill(20'h00320, 20'h00420, 2'd3, 1'b1);
        miss_rd(20'h00302, "R7");
        hit_rd(20'h00303, 20'h00403, "R7");

        // R8: refill of a present page rewrites it without moving the pointer
        fill(20'h00303, 20'h00777, 2'd3, 1'b1);
        hit_rd(20'h00303, 20'h00777, "R8");
        fill(20'h00321, 20'h00421, 2'd3, 1'b1);
        miss_rd(20'h00303, "R8");
        hit_rd(20'h00304, 20'h00404, "R8");
        hit_rd(20'h00321, 20'h00421, "R5");

        // R10: flush together with a refill keeps only the refilled page
        @(negedge clk);
        inv_all = 1'b1; rf_valid = 1'b1;
        rf_vpn = 20'h00555; rf_pfn = 20'h00666; rf_perm = 2'd3; rf_dirty = 1'b1;
        @(negedge clk);
        inv_all = 1'b0; rf_valid = 1'b0;
        hit_rd(20'h00555, 20'h00666, "R10");
        miss_rd(20'h00321, "R10");
        miss_rd(20'h00304, "R10");

        // R1: reset mid-run empties the buffer
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        miss_rd(20'h00555, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule